// File: doc/BRIEF.md
# Quarter-Duty LCD Waveform Sequencer

This block produces the multiplexed drive pattern for a liquid-crystal panel that runs with four common lines and up to 55 segment lines. Every pin gets a 2-bit level code, and an analog stage further down the chain turns that code into a voltage: 0 is ground, 1 is one third of the supply, 2 is two thirds and 3 is full supply. A free-running frame counter clocked by the base oscillator divides each frame into four common phases. Within each phase the drive polarity reverses halfway through, so that no pixel sees a net DC voltage. A 220-bit display image chooses which segments are lit in each phase.

Control inputs pick 1/2 or 1/3 bias, blank every segment, or stop the display in sleep. They can also turn the first segment pins into logic-level output ports, and let the two highest segment pins be taken over by a key-scan circuit. During reset the block forces every output low and returns the shared pins to segment duty.

Top module: `lcd_quad_seq`

## Requirements
- R1: A frame lasts FRAME_LEN base-clock cycles and holds four equal phases of FRAME_LEN/4 cycles each. The cycle count t starts at 0 on the first edge after reset or sleep ends. In phase p (t divided by FRAME_LEN/4), common p+1 is the selected common, and the pattern repeats every frame.
- R2: The second half of each phase is the inverted half. Under 1/3 bias (bias_half=0), the selected common drives code 3 in the first half and code 0 in the second half. The unselected commons drive code 1 in the first half and code 2 in the second half.
- R3: Segment pin n (1-based) takes its image bits from disp[4n-4 +: 4], and bit p pairs with common p+1. A lit segment drives code 0 in the first half and code 3 in the second half. An unlit segment under 1/3 bias drives code 2 in the first half and code 1 in the second half.
- R4: With bias_half=1, every middle level is emitted as code 1. Code 2 then never appears, and the extreme codes are unchanged.
- R5: With seg_blank=1, every segment pin in segment duty drives the unlit waveform, whatever the image holds.
- R6: While sleep is 1, every common pin and every segment pin in segment duty drives code 0, and the frame counter is held at t=0.
- R7: While rst_n is 0, every common and segment output is code 0, port_en is 0 and scan_en is 0.
- R8: port_sel value c turns the lowest min(c,4) segment pins into ports, counting from pin 1. port_en bit i is 1 for every pin i+1 that is a port.
- R9: A port pin n drives code 3 when disp[4n-4] is 1 and code 0 when it is 0. This holds in sleep and ignores seg_blank.
- R10: scan_sel selects the duty of the two highest pins. With 00, both are scan lines. With 01, only pin 54 is a segment. With 1x, both are segments. scan_en[0] marks pin 54 as a scan line and scan_en[1] marks pin 55, and a pin in scan duty drives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_half | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| seg_blank | input | 1 | Forces every segment to the unlit waveform |
| sleep | input | 1 | Darkens the panel and freezes the frame counter |
| port_sel | input | 3 | Number of low segment pins used as ports |
| scan_sel | input | 2 | Duty of the two shared high pins |
| disp | input | 4*SEG_PINS | Display image, four bits per segment pin |
| com_lvl | output | 8 | Level codes of the four commons, common 1 in bits 1:0 |
| seg_lvl | output | 2*SEG_PINS | Level codes of the segment pins, pin 1 in bits 1:0 |
| port_en | output | PORT_PINS | Marks pins in port duty |
| scan_en | output | 2 | Marks the shared pins in scan duty |

## Verification
The bench builds the block with FRAME_LEN set to 32, so each phase lasts 8 cycles and each half phase lasts 4. That brings many whole frames, every polarity flip and the restart after sleep within a few hundred cycles. SEG_PINS and PORT_PINS keep their default values, so the full 220-bit mapping, all eight port_sel codes and both shared high pins are all exercised on the real pin count.

// File: rtl/lcd_quad_seq.sv
module lcd_quad_seq #(
  parameter int SEG_PINS  = 55,
  parameter int PORT_PINS = 4,
  parameter int FRAME_LEN = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bias_half,
  input  logic                    seg_blank,
  input  logic                    sleep,
  input  logic [2:0]              port_sel,
  input  logic [1:0]              scan_sel,
  input  logic [4*SEG_PINS-1:0]   disp,
  output logic [7:0]              com_lvl,
  output logic [2*SEG_PINS-1:0]   seg_lvl,
  output logic [PORT_PINS-1:0]    port_en,
  output logic [1:0]              scan_en
);

  localparam int QTR  = FRAME_LEN / 4;
  localparam int HALF = QTR / 2;
  localparam int SW   = (QTR > 1) ? $clog2(QTR) : 1;

  logic [SW-1:0] sub;
  logic [1:0]    phase;
  logic          pol, live;
  logic [1:0]    com_sel, com_idle, seg_on, seg_off;
  logic [2:0]    nport;
  logic [3:0]    com_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub   <= '0;
      phase <= '0;
    end else if (sleep) begin
      sub   <= '0;
      phase <= '0;
    end else if (sub == SW'(QTR - 1)) begin
      sub   <= '0;
      phase <= phase + 2'd1;
    end else begin
      sub <= sub + SW'(1);
    end
  end

  assign pol      = (sub >= SW'(HALF));
  assign live     = rst_n && !sleep;
  assign com_sel  = pol ? 2'd0 : 2'd3;
  assign seg_on   = pol ? 2'd3 : 2'd0;
  assign com_idle = bias_half ? 2'd1 : (pol ? 2'd2 : 2'd1);
  assign seg_off  = bias_half ? 2'd1 : (pol ? 2'd1 : 2'd2);

  assign nport      = (port_sel > 3'(PORT_PINS)) ? 3'(PORT_PINS) : port_sel;
  assign scan_en[0] = rst_n && (scan_sel == 2'b00);
  assign scan_en[1] = rst_n && !scan_sel[1];

  for (genvar k = 0; k < 4; k++) begin : g_com
    assign com_lvl[2*k +: 2] = !live ? 2'd0 :
                               (phase == 2'(k)) ? com_sel : com_idle;
    assign com_ext[k] = (com_lvl[2*k +: 2] == 2'd0) || (com_lvl[2*k +: 2] == 2'd3);
  end

  for (genvar i = 0; i < PORT_PINS; i++) begin : g_pen
    assign port_en[i] = rst_n && (3'(i) < nport);
  end

  for (genvar n = 0; n < SEG_PINS; n++) begin : g_seg
    logic [3:0] grp;
    logic [1:0] wave;
    assign grp  = disp[4*n +: 4];
    assign wave = !live ? 2'd0 : (grp[phase] && !seg_blank) ? seg_on : seg_off;
    if (n < PORT_PINS) begin : g_port
      assign seg_lvl[2*n +: 2] = port_en[n] ? (grp[0] ? 2'd3 : 2'd0) : wave;
    end else if (n == SEG_PINS - 2) begin : g_scan0
      assign seg_lvl[2*n +: 2] = scan_en[0] ? 2'd0 : wave;
    end else if (n == SEG_PINS - 1) begin : g_scan1
      assign seg_lvl[2*n +: 2] = scan_en[1] ? 2'd0 : wave;
    end else begin : g_plain
      assign seg_lvl[2*n +: 2] = wave;
    end
  end

  assert_one_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> $countones(com_ext) == 1);

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) && !$past(sleep) && !sleep |-> $past(sub) == SW'(QTR - 1));

  assert_no_upper_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bias_half |-> (com_lvl[1:0] != 2'd2) && (com_lvl[3:2] != 2'd2) &&
                  (com_lvl[5:4] != 2'd2) && (com_lvl[7:6] != 2'd2));

  assert_sleep_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> com_lvl == 8'd0);

  assert_reset_dark_R7: assert property (@(posedge clk)
    !rst_n |-> (com_lvl == 8'd0) && (port_en == '0) && (scan_en == 2'b00));

endmodule

// File: tb/test_lcd_quad_seq.sv
module test_lcd_quad_seq;
  localparam int SEGS  = 55;
  localparam int PORTS = 4;
  localparam int FLEN  = 32;
  localparam int Q     = FLEN / 4;

  logic clk = 0;
  logic rst_n = 0;
  logic bias_half = 0, seg_blank = 0, sleep = 0;
  logic [2:0] port_sel = 0;
  logic [1:0] scan_sel = 2'b11;
  logic [4*SEGS-1:0] disp = '0;
  logic [7:0] com_lvl;
  logic [2*SEGS-1:0] seg_lvl;
  logic [PORTS-1:0] port_en;
  logic [1:0] scan_en;

  int checks = 0, fails = 0;
  int m = 0;

  lcd_quad_seq #(.SEG_PINS(SEGS), .PORT_PINS(PORTS), .FRAME_LEN(FLEN)) i_lcd_quad_seq (
    .clk(clk), .rst_n(rst_n), .bias_half(bias_half), .seg_blank(seg_blank), .sleep(sleep),
    .port_sel(port_sel), .scan_sel(scan_sel), .disp(disp), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .port_en(port_en), .scan_en(scan_en));

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n || sleep) m <= 0;
    else m <= (m + 1) % FLEN;

  function automatic logic [7:0] exp_com();
    logic [7:0] r;
    int ph = m / Q;
    bit pl = (m % Q) >= Q / 2;
    for (int k = 0; k < 4; k++) begin
      if (!rst_n || sleep) r[2*k +: 2] = 2'd0;
      else if (k == ph) r[2*k +: 2] = pl ? 2'd0 : 2'd3;
      else r[2*k +: 2] = bias_half ? 2'd1 : (pl ? 2'd2 : 2'd1);
    end
    return r;
  endfunction

  function automatic logic [2*SEGS-1:0] exp_seg();
    logic [2*SEGS-1:0] r;
    int ph = m / Q;
    bit pl = (m % Q) >= Q / 2;
    int np = (port_sel > PORTS) ? PORTS : port_sel;
    for (int n = 0; n < SEGS; n++) begin
      if (!rst_n) r[2*n +: 2] = 2'd0;
      else if (n < np) r[2*n +: 2] = disp[4*n] ? 2'd3 : 2'd0;
      else if (n == SEGS-2 && scan_sel == 2'b00) r[2*n +: 2] = 2'd0;
      else if (n == SEGS-1 && !scan_sel[1]) r[2*n +: 2] = 2'd0;
      else if (sleep) r[2*n +: 2] = 2'd0;
      else if (disp[4*n + ph] && !seg_blank) r[2*n +: 2] = pl ? 2'd3 : 2'd0;
      else r[2*n +: 2] = bias_half ? 2'd1 : (pl ? 2'd1 : 2'd2);
    end
    return r;
  endfunction

  task automatic check_all(string tag);
    logic [7:0] ec = exp_com();
    logic [2*SEGS-1:0] es = exp_seg();
    logic [PORTS-1:0] ep;
    logic [1:0] esc;
    int np = (port_sel > PORTS) ? PORTS : port_sel;
    for (int i = 0; i < PORTS; i++) ep[i] = rst_n && (i < np);
    esc[0] = rst_n && (scan_sel == 2'b00);
    esc[1] = rst_n && !scan_sel[1];
    checks += 4;
    if (com_lvl !== ec) begin fails++; $display("FAIL %s com_lvl actual %h expected %h (m=%0d)", tag, com_lvl, ec, m); end
    if (seg_lvl !== es) begin fails++; $display("FAIL %s seg_lvl actual %h expected %h (m=%0d)", tag, seg_lvl, es, m); end
    if (port_en !== ep) begin fails++; $display("FAIL %s port_en actual %b expected %b", tag, port_en, ep); end
    if (scan_en !== esc) begin fails++; $display("FAIL %s scan_en actual %b expected %b", tag, scan_en, esc); end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_cycles(int n, string tag);
    for (int c = 0; c < n; c++) begin tick(); check_all(tag); end
  endtask

  task automatic t_reset();
    rst_n = 0; port_sel = 3'd4; scan_sel = 2'b00; disp = '1;
    #1; check_all("R7 reset");
    tick(); check_all("R7 reset held");
    rst_n = 1; port_sel = 0; scan_sel = 2'b11;
  endtask

  task automatic t_frame();
    for (int i = 0; i < 4*SEGS; i++) disp[i] = ((i * 7 + 3) % 5) < 2;
    bias_half = 0;
    run_cycles(2 * FLEN, "R1 R2 R3 third bias");
    checks++;
    if (com_lvl[2*(m/Q) +: 2] !== ((m % Q) >= Q/2 ? 2'd0 : 2'd3)) begin
      fails++; $display("FAIL R1 selected common actual %h expected phase %0d", com_lvl, m/Q);
    end
    for (int i = 0; i < 4*SEGS; i++) disp[i] = (i % 3) == 0;
    run_cycles(FLEN, "R3 second pattern");
  endtask

  task automatic t_half();
    bias_half = 1;
    run_cycles(FLEN, "R4 half bias");
    bias_half = 0;
  endtask

  task automatic t_blank();
    seg_blank = 1; disp = '1;
    run_cycles(FLEN, "R5 blank");
    seg_blank = 0;
  endtask

  task automatic t_sleep();
    for (int i = 0; i < 4*SEGS; i++) disp[i] = (i % 4) == 0;
    port_sel = 3'd2;
    run_cycles(5, "R6 before sleep");
    sleep = 1;
    #1; check_all("R6 R9 sleep entry");
    run_cycles(10, "R6 R9 asleep");
    sleep = 0;
    run_cycles(FLEN + 3, "R6 restart at frame start");
    port_sel = 0;
  endtask

  task automatic t_ports();
    for (int c = 0; c < 8; c++) begin
      port_sel = 3'(c);
      disp[0] = c[0]; disp[4] = !c[0]; disp[8] = 1; disp[12] = c[1];
      seg_blank = c[2];
      run_cycles(6, "R8 R9 port select");
    end
    port_sel = 0; seg_blank = 0;
  endtask

  task automatic t_scan();
    disp = '1;
    for (int c = 0; c < 4; c++) begin
      scan_sel = 2'(c);
      run_cycles(10, "R10 scan select");
    end
    scan_sel = 2'b11;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_frame();
    t_half();
    t_blank();
    t_sleep();
    t_ports();
    t_scan();
    rst_n = 0; #1; check_all("R7 reset again");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule